// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block decides the cycle in which an analog-to-digital conversion begins. A small control register holds a 3-bit source select, an auto-trigger enable, a converter enable and a high-speed flag. The select picks one of eight candidate event flags: seven flags from peripherals, plus the converter's own conversion-complete flag for free-running operation. A rising-edge detector follows the selector. When an edge passes the enable gates and no conversion is busy, the block emits a registered start pulse that lasts one clock cycle.

The edge detector sits after the multiplexer. A change of select can therefore produce an edge: moving from a low source to a high source fires a start. Moving into free-running mode never fires a start, even when the conversion-complete flag is already high. The detector's history register updates on every clock, whether or not the block is enabled. Because of this, turning the enables on while a flag is already high does not fire a stale start.

Top module: `adc_trig_sel`

## Requirements
- R1: A synchronous active-high reset clears the select to 000 and clears the auto-trigger, converter-enable and high-speed bits. While reset is held and after it releases, `start_o` and `hs_mode_o` are low and no flag activity fires a start until the block is configured again.
- R2: When `cfg_we` is high at a rising clock edge, the four control fields are captured. `hs_mode_o` shows the stored high-speed bit from the next cycle on. That bit has no effect on when starts occur.
- R3: A rising edge of the selected flag produces `start_o` high in the cycle that follows the clock edge at which the flag is first seen high. A flag that stays high produces no further starts.
- R4: Select value k (1 to 7) routes `ext_flags[k-1]`, so 001 is the analog comparator, 010 is external interrupt 0, 011 is timer0 compare, 100 is timer0 overflow, 101 is timer compare B, 110 is timer1 overflow and 111 is timer1 capture. Edges on the other flags have no effect.
- R5: Changing the stored select from a source whose flag is low to a non-zero source whose flag is high fires exactly one start.
- R6: Changing the stored select to 000 (free-running) never fires a start, even when `conv_done` is high.
- R7: With select 000 and both enables set, each rising edge of `conv_done` fires exactly one start.
- R8: With auto-trigger disabled, no start occurs. The edge history keeps updating, so enabling auto-trigger while the selected flag is already high fires nothing.
- R9: With the converter enable cleared, no start occurs. Enabling it while the selected flag is high fires nothing.
- R10: An edge that arrives while `conv_busy` is high is dropped. `start_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 3 | Trigger source select to store |
| cfg_auto | input | 1 | Auto-trigger enable to store |
| cfg_en | input | 1 | Converter enable to store |
| cfg_hs | input | 1 | High-speed mode bit to store |
| conv_done | input | 1 | Conversion-complete flag (free-running source) |
| ext_flags | input | 7 | Peripheral event flags, bit k-1 for select k |
| conv_busy | input | 1 | Conversion engine busy |
| start_o | output | 1 | One-cycle start-conversion pulse |
| hs_mode_o | output | 1 | Stored high-speed mode bit |

## Verification
The bench goes through every pair of old and new select values with only the old source's flag low. This exposes an edge detector placed before the multiplexer, which would never fire on a switch. It also exposes missing suppression on entry into free-running mode, which would fire on every move to 000. A sweep of every select value against every flag catches a routing off by one, which would fire on a neighbouring source. The enable tests first raise a flag while the block is gated off and then open the gate. A detector that stops updating its history while disabled would fire a late start at that point. Held flags and back-to-back edges under busy show whether a design retriggers on a level or stretches the start pulse.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned TRIG_SEL_W = 3;

  typedef enum logic [TRIG_SEL_W-1:0] {
    SRC_FREE  = 3'd0,
    SRC_ACMP  = 3'd1,
    SRC_EXT0  = 3'd2,
    SRC_T0CMP = 3'd3,
    SRC_T0OVF = 3'd4,
    SRC_TCMPB = 3'd5,
    SRC_T1OVF = 3'd6,
    SRC_T1CAP = 3'd7
  } trig_src_e;

  typedef struct packed {
    logic auto_en;
    logic adc_en;
    logic hs_mode;
  } trig_ctrl_t;
endpackage

// File: rtl/adc_trig_cfg.sv
module adc_trig_cfg
  import adc_trig_pkg::*;
#(
  parameter int unsigned SEL_W = TRIG_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel_d,
  input  trig_ctrl_t       ctrl_d,
  output logic [SEL_W-1:0] sel_q,
  output trig_ctrl_t       ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      sel_q  <= sel_d;
      ctrl_q <= ctrl_d;
    end
  end

  // Stored fields change only on a write.
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(we) |-> $stable(sel_q) && $stable(ctrl_q));
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NSRC = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             done_flag,
  input  logic [NSRC-2:0]  ext_flags,
  output logic             edge_o
);
  logic mux_sig;
  logic prev_sig;
  logic prev_free;
  logic entering_free;

  // Source 0 is the conversion-complete flag; source k maps to ext_flags[k-1].
  always_comb begin
    mux_sig = done_flag;
    for (int k = 1; k < int'(NSRC); k++) begin
      if (sel == SEL_W'(k)) mux_sig = ext_flags[k-1];
    end
  end

  // History runs every clock regardless of enables.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sig  <= 1'b0;
      prev_free <= 1'b1;
    end else begin
      prev_sig  <= mux_sig;
      prev_free <= (sel == '0);
    end
  end

  assign entering_free = (sel == '0) && !prev_free;
  assign edge_o        = mux_sig && !prev_sig && !entering_free;

  // An edge always finds the selected flag low in the previous cycle.
  assert_edge_from_low_R3: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o || !$stable(sel));
endmodule

// File: rtl/adc_trig_start.sv
module adc_trig_start (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  input  logic auto_en,
  input  logic adc_en,
  input  logic busy,
  output logic start_o
);
  logic fire;

  assign fire = edge_i && auto_en && adc_en && !busy && !start_o;

  always_ff @(posedge clk) begin
    if (rst) start_o <= 1'b0;
    else     start_o <= fire;
  end

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  assert_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(!busy));
  assert_adc_gate_R9: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(adc_en));
  assert_auto_gate_R8: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(auto_en));
  assert_needs_edge_R3: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(edge_i));
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
#(
  parameter int unsigned SEL_W = TRIG_SEL_W,
  localparam int unsigned NSRC = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_auto,
  input  logic             cfg_en,
  input  logic             cfg_hs,
  input  logic             conv_done,
  input  logic [NSRC-2:0]  ext_flags,
  input  logic             conv_busy,
  output logic             start_o,
  output logic             hs_mode_o
);
  logic [SEL_W-1:0] sel_q;
  trig_ctrl_t       ctrl_d;
  trig_ctrl_t       ctrl_q;
  logic             edge_w;

  always_comb begin
    ctrl_d.auto_en = cfg_auto;
    ctrl_d.adc_en  = cfg_en;
    ctrl_d.hs_mode = cfg_hs;
  end

  adc_trig_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel_d(cfg_sel),
    .ctrl_d(ctrl_d), .sel_q(sel_q), .ctrl_q(ctrl_q)
  );

  adc_trig_edge #(.SEL_W(SEL_W)) u_edge (
    .clk(clk), .rst(rst), .sel(sel_q), .done_flag(conv_done),
    .ext_flags(ext_flags), .edge_o(edge_w)
  );

  adc_trig_start u_start (
    .clk(clk), .rst(rst), .edge_i(edge_w), .auto_en(ctrl_q.auto_en),
    .adc_en(ctrl_q.adc_en), .busy(conv_busy), .start_o(start_o)
  );

  assign hs_mode_o = ctrl_q.hs_mode;

  // Entering free-running mode never produces a start.
  assert_free_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sel_q) && sel_q == '0) |=> !start_o);
endmodule

// File: tb/adc_trig_sel_tb.sv
module adc_trig_sel_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic       cfg_auto = 1'b0, cfg_en = 1'b0, cfg_hs = 1'b0;
  logic       conv_done = 1'b0;
  logic [6:0] ext_flags = '0;
  logic       conv_busy = 1'b0;
  logic       start_o, hs_mode_o;

  int checks = 0;
  int errors = 0;
  int n_start = 0;
  int mark = 0;

  always #2 clk = ~clk;

  adc_trig_sel u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_auto(cfg_auto), .cfg_en(cfg_en), .cfg_hs(cfg_hs),
    .conv_done(conv_done), .ext_flags(ext_flags), .conv_busy(conv_busy),
    .start_o(start_o), .hs_mode_o(hs_mode_o)
  );

  always @(posedge clk) begin
    #1;
    if (start_o === 1'b1) n_start++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] s, logic a, logic e, logic h);
    cfg_we = 1'b1; cfg_sel = s; cfg_auto = a; cfg_en = e; cfg_hs = h;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    tick(3);
    chk("R1 start in reset", int'(start_o), 0);
    chk("R1 hs in reset", int'(hs_mode_o), 0);
    rst = 1'b0;
    tick(1);
    mark = n_start;
    ext_flags = 7'h7f; conv_done = 1'b1;
    tick(4);
    chk("R1 no start after reset", n_start - mark, 0);
    ext_flags = '0; conv_done = 1'b0;
    tick(2);

    // R2: high-speed bit stored, no effect on triggering
    wr(3'd5, 1'b1, 1'b1, 1'b1);
    tick(1);
    chk("R2 hs stored", int'(hs_mode_o), 1);
    mark = n_start;
    ext_flags[4] = 1'b1;
    tick(3);
    chk("R2 trigger with hs", n_start - mark, 1);
    ext_flags[4] = 1'b0;
    wr(3'd5, 1'b1, 1'b1, 1'b0);
    tick(1);
    chk("R2 hs cleared", int'(hs_mode_o), 0);

    // R3: latency, single pulse on held level
    wr(3'd2, 1'b1, 1'b1, 1'b0);
    tick(2);
    mark = n_start;
    ext_flags[1] = 1'b1;
    tick(1);
    chk("R3 start latency", int'(start_o), 1);
    tick(1);
    chk("R10 single cycle", int'(start_o), 0);
    tick(4);
    chk("R3 held level one start", n_start - mark, 1);
    ext_flags[1] = 1'b0;
    tick(2);

    // R4: every select against every flag
    for (int s = 1; s < 8; s++) begin
      wr(3'(s), 1'b1, 1'b1, 1'b0);
      tick(2);
      for (int i = 0; i < 7; i++) begin
        mark = n_start;
        ext_flags[i] = 1'b1;
        tick(3);
        ext_flags[i] = 1'b0;
        tick(2);
        chk($sformatf("R4 sel %0d flag %0d", s, i), n_start - mark,
            (i == s - 1) ? 1 : 0);
      end
    end

    // R5 / R6: every select switch with only the old source low
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        if (a != b) begin
          ext_flags = '0; conv_done = 1'b0;
          wr(3'(a), 1'b1, 1'b1, 1'b0);
          tick(3);
          ext_flags = 7'h7f; conv_done = 1'b1;
          if (a == 0) conv_done = 1'b0;
          else ext_flags[a-1] = 1'b0;
          tick(3);
          mark = n_start;
          wr(3'(b), 1'b1, 1'b1, 1'b0);
          tick(3);
          if (b == 0)
            chk($sformatf("R6 switch %0d to 0", a), n_start - mark, 0);
          else
            chk($sformatf("R5 switch %0d to %0d", a, b), n_start - mark, 1);
          ext_flags = '0; conv_done = 1'b0;
          tick(2);
        end
      end
    end

    // R7: free-running on conversion-complete edges
    wr(3'd0, 1'b1, 1'b1, 1'b0);
    tick(2);
    mark = n_start;
    conv_done = 1'b1;
    tick(1);
    chk("R7 free-run latency", int'(start_o), 1);
    tick(3);
    conv_done = 1'b0;
    tick(2);
    conv_done = 1'b1;
    tick(3);
    chk("R7 free-run two edges", n_start - mark, 2);
    conv_done = 1'b0;
    tick(2);

    // R8: auto-trigger gating and history
    wr(3'd3, 1'b0, 1'b1, 1'b0);
    tick(2);
    mark = n_start;
    ext_flags[2] = 1'b1;
    tick(3);
    chk("R8 auto off", n_start - mark, 0);
    wr(3'd3, 1'b1, 1'b1, 1'b0);
    tick(3);
    chk("R8 enable with level high", n_start - mark, 0);
    ext_flags[2] = 1'b0;
    tick(2);
    ext_flags[2] = 1'b1;
    tick(3);
    chk("R8 edge after enable", n_start - mark, 1);
    ext_flags[2] = 1'b0;
    tick(2);

    // R9: converter enable gating
    wr(3'd6, 1'b1, 1'b0, 1'b0);
    tick(2);
    mark = n_start;
    ext_flags[5] = 1'b1;
    tick(3);
    chk("R9 adc off", n_start - mark, 0);
    wr(3'd6, 1'b1, 1'b1, 1'b0);
    tick(3);
    chk("R9 enable with level high", n_start - mark, 0);
    ext_flags[5] = 1'b0;
    tick(2);
    ext_flags[5] = 1'b1;
    tick(3);
    chk("R9 edge after enable", n_start - mark, 1);
    ext_flags[5] = 1'b0;
    tick(2);

    // R10: busy drops edges; back-to-back edges
    wr(3'd1, 1'b1, 1'b1, 1'b0);
    tick(2);
    mark = n_start;
    conv_busy = 1'b1;
    ext_flags[0] = 1'b1;
    tick(3);
    chk("R10 busy drops edge", n_start - mark, 0);
    ext_flags[0] = 1'b0;
    conv_busy = 1'b0;
    tick(3);
    chk("R10 busy release no start", n_start - mark, 0);
    ext_flags[0] = 1'b1;
    tick(1);
    ext_flags[0] = 1'b0;
    tick(1);
    ext_flags[0] = 1'b1;
    tick(1);
    ext_flags[0] = 1'b0;
    tick(3);
    chk("R10 spaced edges", n_start - mark, 2);

    // R1: reset mid-run clears configuration
    wr(3'd1, 1'b1, 1'b1, 1'b1);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    chk("R1 hs after reset", int'(hs_mode_o), 0);
    mark = n_start;
    ext_flags[0] = 1'b1;
    tick(3);
    chk("R1 config cleared", n_start - mark, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule